// File: doc/BRIEF.md
# Audio Sample FIFO Pair with DMA Request Thresholds

This block holds the sample buffers between a software/DMA side and a serial audio shifter. It contains one transmit queue (filled by software, drained by the shifter) and one receive queue (filled by the shifter, drained by software). Each queue is 64 words of 32 bits. The fill level of each queue is compared against programmable levels to raise a DMA request and a more urgent panic request. A set of status flags reports emptiness, room, data presence and sticky error conditions.

The whole block runs on one clock. `pcm_tick` is a one-cycle enable that stands for an edge of the serial bit clock. The flush requests for each queue and the handshake bit act only after two such ticks have been counted. Software can therefore write the handshake bit and poll it until the written value comes back. That tells it the slow serial domain has caught up and any flush issued before it has completed.

Top module: `audio_fifo_dreq`

## Requirements
- R1: `thr_rdata` resets to 0x10303020. A write on `thr_wr` stores `thr_wdata` with its reserved bits forced to zero, so 0xFFFFFFFF reads back as 0x7F7F7F7F. The level fields sit at fixed bit positions: transmit panic level in bits 30:24, receive panic level in bits 22:16, transmit request level in bits 14:8 and receive request level in bits 6:0.
- R2: The transmit queue returns words on `ser_tx_data` in write order and holds 64 words. `tx_empty` is high exactly when it holds none. `tx_can_wr` is high exactly when it holds fewer than 64.
- R3: While `dma_en` is high, `tx_dreq` is high exactly when the transmit fill is below the transmit request level, and `tx_panic` is high exactly when the fill is below the transmit panic level.
- R4: The receive queue returns words on `rx_rdata` in arrival order and holds 64 words. `rx_has_data` is high when it holds at least one word. `rx_above` is high when the fill exceeds the receive request level, independent of `dma_en`.
- R5: While `dma_en` is high, `rx_dreq` is high exactly when the receive fill exceeds the receive request level, and `rx_panic` is high exactly when the fill exceeds the receive panic level.
- R6: While `dma_en` is low, `tx_dreq`, `tx_panic`, `rx_dreq` and `rx_panic` are all low.
- R7: A push into a full transmit queue is discarded and sets `tx_err` on the next cycle. `tx_err` stays set until a cycle with `tx_err_clr` high and no new overflow.
- R8: A pop from an empty receive queue shows 0 on `rx_rdata` and sets `rx_err` on the next cycle. `rx_err` stays set until a cycle with `rx_err_clr` high and no new underflow.
- R9: A pulse on `tx_clr` or `rx_clr` leaves that queue untouched until the second `pcm_tick` after the pulse. At that clock edge the queue becomes empty.
- R10: A value written with `sync_wr`/`sync_wval` appears on `sync_rd` at the clock edge of the second `pcm_tick` after the write. Before that edge `sync_rd` keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pcm_tick | input | 1 | One-cycle stand-in for a serial bit-clock edge |
| dma_en | input | 1 | Enables the four request outputs |
| thr_wr | input | 1 | Write strobe for the level register |
| thr_wdata | input | 32 | Level register write value |
| thr_rdata | output | 32 | Level register contents |
| tx_push | input | 1 | Software writes a transmit word |
| tx_wdata | input | 32 | Transmit word |
| tx_empty | output | 1 | Transmit queue holds nothing |
| tx_can_wr | output | 1 | Transmit queue has room |
| tx_dreq | output | 1 | Transmit DMA request |
| tx_panic | output | 1 | Transmit urgent request |
| tx_err | output | 1 | Sticky transmit overflow flag |
| tx_err_clr | input | 1 | Write-1 clear of `tx_err` |
| tx_clr | input | 1 | Flush request for the transmit queue |
| ser_tx_pop | input | 1 | Shifter takes the head transmit word |
| ser_tx_data | output | 32 | Head transmit word, 0 when empty |
| ser_rx_push | input | 1 | Shifter delivers a received word |
| ser_rx_data | input | 32 | Received word |
| rx_pop | input | 1 | Software reads a receive word |
| rx_rdata | output | 32 | Head receive word, 0 when empty |
| rx_has_data | output | 1 | Receive queue holds a word |
| rx_above | output | 1 | Receive fill exceeds request level |
| rx_dreq | output | 1 | Receive DMA request |
| rx_panic | output | 1 | Receive urgent request |
| rx_err | output | 1 | Sticky receive underflow flag |
| rx_err_clr | input | 1 | Write-1 clear of `rx_err` |
| rx_clr | input | 1 | Flush request for the receive queue |
| sync_wr | input | 1 | Handshake bit write strobe |
| sync_wval | input | 1 | Handshake bit value |
| sync_rd | output | 1 | Handshake bit as seen after two ticks |

## Verification
Each queue is filled one word at a time from empty to full and one word past it. At every fill level the request, panic and status outputs are compared with the level arithmetic. This separates a `<` from a `<=` comparison and a swapped field from the correct one, because the chosen request and panic levels differ for each direction. Draining afterwards with counting data patterns confirms order and depth. Overflow and underflow probes separate a dropped word from a stored one. Flush and handshake sequences interleave idle cycles with ticks, which separates counting ticks from counting clock cycles, and one tick from two.

// File: rtl/audio_fifo_pkg.sv
package audio_fifo_pkg;
    localparam int LVL_W     = 7;
    localparam int TXP_LSB   = 24;
    localparam int RXP_LSB   = 16;
    localparam int TXR_LSB   = 8;
    localparam int RXR_LSB   = 0;
    localparam logic [31:0] THR_MASK  = 32'h7F7F_7F7F;
    localparam logic [31:0] THR_RESET = 32'h1030_3020;

    typedef struct packed {
        logic [LVL_W-1:0] tx_panic;
        logic [LVL_W-1:0] rx_panic;
        logic [LVL_W-1:0] tx_req;
        logic [LVL_W-1:0] rx_req;
    } levels_t;

    function automatic levels_t unpack_levels(input logic [31:0] r);
        levels_t l;
        l.tx_panic = r[TXP_LSB +: LVL_W];
        l.rx_panic = r[RXP_LSB +: LVL_W];
        l.tx_req   = r[TXR_LSB +: LVL_W];
        l.rx_req   = r[RXR_LSB +: LVL_W];
        return l;
    endfunction
endpackage

// File: rtl/afd_queue.sv
module afd_queue #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] cnt;
    } qstate_t;

    qstate_t st_q, st_d;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    assign full    = (st_q.cnt == CNT_W'(DEPTH));
    assign empty   = (st_q.cnt == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wptr = (st_q.wptr == PTR_W'(DEPTH-1)) ? '0 : st_q.wptr + 1'b1;
            if (do_pop)  st_d.rptr = (st_q.rptr == PTR_W'(DEPTH-1)) ? '0 : st_q.rptr + 1'b1;
            st_d.cnt = st_q.cnt + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wptr] <= wdata;
    end

    assign rdata = empty ? '0 : mem_q[st_q.rptr];
    assign count = st_q.cnt;
endmodule

// File: rtl/afd_tick_delay.sv
module afd_tick_delay #(
    parameter int TICKS = 2,
    localparam int C_W = $clog2(TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic req,
    output logic fire
);
    typedef struct packed {
        logic           pend;
        logic [C_W-1:0] cnt;
    } dstate_t;

    dstate_t st_q, st_d;
    logic last;

    assign last = (st_q.cnt == C_W'(TICKS-1));
    assign fire = st_q.pend && !req && tick && last;

    always_comb begin
        st_d = st_q;
        if (req) begin
            st_d.pend = 1'b1;
            st_d.cnt  = '0;
        end else if (st_q.pend && tick) begin
            if (last) st_d = '0;
            else      st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/audio_fifo_dreq.sv
module audio_fifo_dreq
    import audio_fifo_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int WIDTH = 32,
    parameter int TICKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pcm_tick,
    input  logic             dma_en,
    input  logic             thr_wr,
    input  logic [31:0]      thr_wdata,
    output logic [31:0]      thr_rdata,
    input  logic             tx_push,
    input  logic [WIDTH-1:0] tx_wdata,
    output logic             tx_empty,
    output logic             tx_can_wr,
    output logic             tx_dreq,
    output logic             tx_panic,
    output logic             tx_err,
    input  logic             tx_err_clr,
    input  logic             tx_clr,
    input  logic             ser_tx_pop,
    output logic [WIDTH-1:0] ser_tx_data,
    input  logic             ser_rx_push,
    input  logic [WIDTH-1:0] ser_rx_data,
    input  logic             rx_pop,
    output logic [WIDTH-1:0] rx_rdata,
    output logic             rx_has_data,
    output logic             rx_above,
    output logic             rx_dreq,
    output logic             rx_panic,
    output logic             rx_err,
    input  logic             rx_err_clr,
    input  logic             rx_clr,
    input  logic             sync_wr,
    input  logic             sync_wval,
    output logic             sync_rd
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int N_DLY = 3;

    typedef struct packed {
        logic [31:0] thr;
        logic        tx_err;
        logic        rx_err;
        logic        sync_tgt;
        logic        sync_rd;
    } top_state_t;

    top_state_t st_q, st_d;
    levels_t    lv;
    logic [N_DLY-1:0] dly_req, dly_fire;
    logic [CNT_W-1:0] tx_cnt, rx_cnt;
    logic tx_full, tx_mt, rx_full, rx_mt;
    int   tx_fill, rx_fill;

    assign dly_req = {sync_wr, rx_clr, tx_clr};

    for (genvar g = 0; g < N_DLY; g++) begin : g_dly
        afd_tick_delay #(.TICKS(TICKS)) u_dly (
            .clk(clk), .rst_n(rst_n), .tick(pcm_tick),
            .req(dly_req[g]), .fire(dly_fire[g])
        );
    end

    afd_queue #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(dly_fire[0]),
        .push(tx_push), .wdata(tx_wdata),
        .pop(ser_tx_pop), .rdata(ser_tx_data),
        .count(tx_cnt), .full(tx_full), .empty(tx_mt)
    );

    afd_queue #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(dly_fire[1]),
        .push(ser_rx_push), .wdata(ser_rx_data),
        .pop(rx_pop), .rdata(rx_rdata),
        .count(rx_cnt), .full(rx_full), .empty(rx_mt)
    );

    assign lv      = unpack_levels(st_q.thr);
    assign tx_fill = int'(tx_cnt);
    assign rx_fill = int'(rx_cnt);

    always_comb begin
        st_d = st_q;
        if (thr_wr) st_d.thr = thr_wdata & THR_MASK;
        if (tx_err_clr) st_d.tx_err = 1'b0;
        if (tx_push && tx_full) st_d.tx_err = 1'b1;
        if (rx_err_clr) st_d.rx_err = 1'b0;
        if (rx_pop && rx_mt) st_d.rx_err = 1'b1;
        if (sync_wr) st_d.sync_tgt = sync_wval;
        if (dly_fire[2]) st_d.sync_rd = st_q.sync_tgt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.thr <= THR_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign thr_rdata   = st_q.thr;
    assign tx_empty    = tx_mt;
    assign tx_can_wr   = !tx_full;
    assign rx_has_data = !rx_mt;
    assign rx_above    = rx_fill > int'(lv.rx_req);
    assign tx_dreq     = dma_en && (tx_fill < int'(lv.tx_req));
    assign tx_panic    = dma_en && (tx_fill < int'(lv.tx_panic));
    assign rx_dreq     = dma_en && rx_above;
    assign rx_panic    = dma_en && (rx_fill > int'(lv.rx_panic));
    assign tx_err      = st_q.tx_err;
    assign rx_err      = st_q.rx_err;
    assign sync_rd     = st_q.sync_rd;

    logic unused_rx_full;
    assign unused_rx_full = rx_full;
endmodule

// File: rtl/audio_fifo_dreq_chk.sv
module audio_fifo_dreq_chk (
    input logic clk,
    input logic rst_n,
    input logic pcm_tick,
    input logic dma_en,
    input logic tx_push,
    input logic tx_empty,
    input logic tx_can_wr,
    input logic tx_dreq,
    input logic tx_panic,
    input logic tx_err,
    input logic tx_err_clr,
    input logic rx_pop,
    input logic rx_has_data,
    input logic rx_dreq,
    input logic rx_panic,
    input logic rx_err,
    input logic rx_err_clr,
    input logic sync_rd
);
    // R6
    a_r6_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |-> !(tx_dreq || tx_panic || rx_dreq || rx_panic));
    // R2
    a_r2_empty_has_room: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> tx_can_wr);
    // R7
    a_r7_overflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && !tx_can_wr) |=> tx_err);
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_err && !tx_err_clr) |=> tx_err);
    // R8
    a_r8_underflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && !rx_has_data) |=> rx_err);
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_err && !rx_err_clr) |=> rx_err);
    // R10
    a_r10_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !pcm_tick |=> $stable(sync_rd));
endmodule

bind audio_fifo_dreq audio_fifo_dreq_chk u_chk (.*);

// File: tb/tb_audio_fifo_dreq.sv
module tb_audio_fifo_dreq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pcm_tick = 0, dma_en = 0, thr_wr = 0;
    logic [31:0] thr_wdata = 0, thr_rdata;
    logic tx_push = 0;
    logic [31:0] tx_wdata = 0;
    logic tx_empty, tx_can_wr, tx_dreq, tx_panic, tx_err;
    logic tx_err_clr = 0, tx_clr = 0, ser_tx_pop = 0;
    logic [31:0] ser_tx_data;
    logic ser_rx_push = 0;
    logic [31:0] ser_rx_data = 0, rx_rdata;
    logic rx_pop = 0;
    logic rx_has_data, rx_above, rx_dreq, rx_panic, rx_err;
    logic rx_err_clr = 0, rx_clr = 0, sync_wr = 0, sync_wval = 0, sync_rd;

    int checks = 0, failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    audio_fifo_dreq dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    localparam int TXP = 20, RXP = 50, TXR = 40, RXR = 10;

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        #1;
        chk("R1 reset levels", thr_rdata, 32'h1030_3020);
        chk("R2 reset empty", {31'd0, tx_empty}, 1);
        chk("R4 reset no data", {31'd0, rx_has_data}, 0);
        chk("R10 reset sync", {31'd0, sync_rd}, 0);

        thr_wr = 1; thr_wdata = 32'hFFFF_FFFF; cyc(); thr_wr = 0; #1;
        chk("R1 reserved zero", thr_rdata, 32'h7F7F_7F7F);
        thr_wr = 1; thr_wdata = (TXP << 24) | (RXP << 16) | (TXR << 8) | RXR;
        cyc(); thr_wr = 0;

        // R6: masked while disabled, empty TX would otherwise request
        #1;
        chk("R6 tx_dreq masked", {31'd0, tx_dreq}, 0);
        chk("R6 tx_panic masked", {31'd0, tx_panic}, 0);
        dma_en = 1;

        // R2/R3 sweep of TX fill
        for (int n = 0; n <= 64; n++) begin
            #1;
            chk("R3 tx_dreq", {31'd0, tx_dreq}, (n < TXR));
            chk("R3 tx_panic", {31'd0, tx_panic}, (n < TXP));
            chk("R2 tx_empty", {31'd0, tx_empty}, (n == 0));
            chk("R2 tx_can_wr", {31'd0, tx_can_wr}, (n < 64));
            tx_push = 1; tx_wdata = 32'hA500_0000 + n;
            cyc();
        end
        tx_push = 0; #1;
        chk("R7 tx_err set", {31'd0, tx_err}, 1);
        cyc(); #1;
        chk("R7 tx_err sticky", {31'd0, tx_err}, 1);
        tx_err_clr = 1; cyc(); tx_err_clr = 0; #1;
        chk("R7 tx_err cleared", {31'd0, tx_err}, 0);
        for (int n = 0; n < 64; n++) begin
            #1;
            chk("R2 tx order", ser_tx_data, 32'hA500_0000 + n);
            ser_tx_pop = 1; cyc();
        end
        ser_tx_pop = 0; #1;
        chk("R2 tx drained", {31'd0, tx_empty}, 1);

        // R4/R5 sweep of RX fill
        for (int n = 0; n <= 64; n++) begin
            #1;
            if (n < 64) begin
                chk("R5 rx_dreq", {31'd0, rx_dreq}, (n > RXR));
                chk("R5 rx_panic", {31'd0, rx_panic}, (n > RXP));
                chk("R4 rx_above", {31'd0, rx_above}, (n > RXR));
                chk("R4 rx_has_data", {31'd0, rx_has_data}, (n > 0));
                ser_rx_push = 1; ser_rx_data = 32'h5A00_0000 + n;
            end else begin
                ser_rx_push = 1; ser_rx_data = 32'hDEAD_BEEF;
            end
            cyc();
        end
        ser_rx_push = 0;
        dma_en = 0; #1;
        chk("R6 rx_dreq masked", {31'd0, rx_dreq}, 0);
        chk("R6 rx_panic masked", {31'd0, rx_panic}, 0);
        chk("R4 rx_above unmasked", {31'd0, rx_above}, 1);
        dma_en = 1;
        for (int n = 0; n < 64; n++) begin
            #1;
            chk("R4 rx order", rx_rdata, 32'h5A00_0000 + n);
            rx_pop = 1; cyc();
        end
        #1;
        chk("R8 rx zero on empty", rx_rdata, 0);
        chk("R8 rx_err before", {31'd0, rx_err}, 0);
        cyc(); rx_pop = 0; #1;
        chk("R8 rx_err set", {31'd0, rx_err}, 1);
        rx_err_clr = 1; cyc(); rx_err_clr = 0; #1;
        chk("R8 rx_err cleared", {31'd0, rx_err}, 0);

        // R9 TX flush timing
        for (int n = 0; n < 3; n++) begin
            tx_push = 1; tx_wdata = n; cyc();
        end
        tx_push = 0;
        tx_clr = 1; cyc(); tx_clr = 0;
        cyc(); cyc(); #1;
        chk("R9 tx no tick yet", {31'd0, tx_empty}, 0);
        pcm_tick = 1; cyc(); pcm_tick = 0; cyc(); #1;
        chk("R9 tx one tick", {31'd0, tx_empty}, 0);
        chk("R9 tx data kept", ser_tx_data, 0);
        pcm_tick = 1; cyc(); pcm_tick = 0; #1;
        chk("R9 tx flushed", {31'd0, tx_empty}, 1);

        // R9 RX flush timing
        for (int n = 0; n < 2; n++) begin
            ser_rx_push = 1; ser_rx_data = 7 + n; cyc();
        end
        ser_rx_push = 0;
        rx_clr = 1; cyc(); rx_clr = 0;
        pcm_tick = 1; cyc(); pcm_tick = 0; #1;
        chk("R9 rx one tick", {31'd0, rx_has_data}, 1);
        pcm_tick = 1; cyc(); pcm_tick = 0; #1;
        chk("R9 rx flushed", {31'd0, rx_has_data}, 0);

        // R10 handshake bit
        sync_wr = 1; sync_wval = 1; cyc(); sync_wr = 0;
        cyc(); #1;
        chk("R10 no tick", {31'd0, sync_rd}, 0);
        pcm_tick = 1; cyc(); pcm_tick = 0; #1;
        chk("R10 one tick", {31'd0, sync_rd}, 0);
        pcm_tick = 1; cyc(); pcm_tick = 0; #1;
        chk("R10 two ticks", {31'd0, sync_rd}, 1);
        sync_wr = 1; sync_wval = 0; cyc(); sync_wr = 0;
        pcm_tick = 1; cyc(); #1;
        chk("R10 clear one tick", {31'd0, sync_rd}, 1);
        cyc(); pcm_tick = 0; #1;
        chk("R10 clear two ticks", {31'd0, sync_rd}, 0);

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule